// File: doc/BRIEF.md
# Serial SRAM SPI Slave

This block is a synthesizable SPI slave that looks, from the bus, like a small serial static RAM. A master lowers chip select and shifts in a one-byte command. Read and write commands are followed by a three-byte address and then a run of data bytes. Two further commands write and read a mode register. The mode register picks one of three auto-increment rules: a single byte per address, wrap-around inside a 32-byte page, or a free run through the whole array. The array is a register memory of `DEPTH` bytes, where `DEPTH` is a power of two. Only the low address bits index the array, so addresses wrap modulo `DEPTH`.

SCK, chip select and MOSI are brought into the system clock domain through synchronizers. All decoding then runs on the system clock. For this reason SCK must stay in each phase for at least eight system clock cycles. A separate debug port reads any array byte, with one cycle of latency, without involving the serial interface. Typical uses are as a stand-in memory for a firmware SPI driver in an FPGA prototype, or as a target behind an SPI master under test.

Top module: `sram_spi_dev`

## Requirements
- R1: After synchronous reset the mode register holds sequential mode (bits 7:6 = 01), and `spi_miso` and `spi_miso_oe` are low.
- R2: Command byte 0x02 starts a write and 0x03 starts a read. Each is followed by a 24-bit address sent most significant bit first, and the array byte used is the address modulo `DEPTH`.
- R3: MOSI is taken on the rising edge of SCK, MISO changes only after a falling edge of SCK, SCK idles low, and every byte travels most significant bit first.
- R4: In sequential mode (01), each completed data byte advances the address by one through the whole array, wrapping from `DEPTH`-1 to 0.
- R5: In page mode (10), each completed data byte advances the low five address bits, wrapping from 31 to 0, while the upper address bits hold.
- R6: In byte mode (00, and the reserved code 11), only the first data byte after an address is accessed. Later write bytes leave the array unchanged, and later read bytes return 0x00.
- R7: Command 0x01 stores bits 7:6 of the next byte as the mode and ignores its other bits. Command 0x05 returns {mode, 6'b0} on every following byte.
- R8: Raising chip select ends the transaction and returns the command decoder to its idle state. A partly shifted byte is dropped and writes nothing.
- R9: While chip select is high, `spi_miso_oe` is low and `spi_miso` is low (or high-impedance when `USE_TRISTATE` is set). While chip select is low, `spi_miso_oe` is high.
- R10: After an unrecognised command byte, the rest of the transaction changes neither the array nor the mode, and MISO stays 0.
- R11: `dbg_data` shows the array byte at `dbg_addr` one clock after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the master, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data in from the master |
| spi_miso | output | 1 | Serial data out to the master |
| spi_miso_oe | output | 1 | High while the device drives MISO |
| dbg_addr | input | AW | Debug read address, AW = log2(DEPTH) |
| dbg_data | output | 8 | Registered debug read data |

## Verification
The bench targets the corner cases of the addressing rules. It writes across the top of the array, where a design that failed to wrap would lose or misplace data. It writes across a page end, where a design that carried into the upper bits would corrupt the next page. In byte mode it streams extra bytes, where a design that ignored the mode would overwrite the neighbouring byte or return stale data instead of zeros. It also drops chip select in the middle of a byte and in the middle of a command. A decoder that failed to reset would then either commit the half-shifted byte or misread the following command. Mode writes that set all the low bits check that unused bits never reach the mode read-back. Unknown commands followed by write-like traffic check that nothing is written.

// File: rtl/sram_spi_pkg.sv
package sram_spi_pkg;

  typedef enum logic [1:0] {
    MODE_BYTE = 2'b00,
    MODE_SEQ  = 2'b01,
    MODE_PAGE = 2'b10,
    MODE_RSVD = 2'b11
  } acc_mode_e;

  typedef enum logic [2:0] {
    ST_CMD,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA,
    ST_MODEW,
    ST_MODER,
    ST_IGNORE
  } ctl_state_e;

  localparam logic [7:0] OP_WRITE  = 8'h02;
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_WRMODE = 8'h01;
  localparam logic [7:0] OP_RDMODE = 8'h05;

  localparam int ADDR_W     = 24;
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam int PAGE_BITS  = 5;

endpackage

// File: rtl/sram_spi_sync.sv
module sram_spi_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_n_s,
  output logic mosi_s
);

  logic [SYNC_STAGES-1:0] sck_p;
  logic [SYNC_STAGES-1:0] cs_p;
  logic [SYNC_STAGES-1:0] mosi_p;
  logic                   sck_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_p    <= '0;
      cs_p     <= '1;
      mosi_p   <= '0;
      sck_last <= 1'b0;
    end else begin
      sck_p    <= {sck_p[SYNC_STAGES-2:0], sck};
      cs_p     <= {cs_p[SYNC_STAGES-2:0], cs_n};
      mosi_p   <= {mosi_p[SYNC_STAGES-2:0], mosi};
      sck_last <= sck_p[SYNC_STAGES-1];
    end
  end

  assign sck_rise = sck_p[SYNC_STAGES-1] & ~sck_last;
  assign sck_fall = ~sck_p[SYNC_STAGES-1] & sck_last;
  assign cs_n_s   = cs_p[SYNC_STAGES-1];
  assign mosi_s   = mosi_p[SYNC_STAGES-1];

endmodule

// File: rtl/sram_spi_mem.sv
module sram_spi_mem #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata,
  input  logic [AW-1:0] dbg_addr,
  output logic [7:0]    dbg_data
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata    <= mem[raddr];
    dbg_data <= mem[dbg_addr];
  end

endmodule

// File: rtl/sram_spi_ctrl.sv
module sram_spi_ctrl
  import sram_spi_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_rise_raw,
  input  logic              sck_fall_raw,
  input  logic              cs_n_s,
  input  logic              mosi_s,
  input  logic [7:0]        rd_data,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [7:0]        mem_wdata,
  output logic              miso_q,
  output logic              miso_oe,
  output logic              byte_done,
  output ctl_state_e        state_q,
  output acc_mode_e         mode_q,
  output logic [ADDR_W-1:0] addr_q
);

  logic [2:0] bit_cnt_q;
  logic [6:0] rx_q;
  logic [1:0] abyte_q;
  logic       is_read_q;
  logic [7:0] tx_q;
  logic [7:0] rx_byte;
  logic       sck_rise;
  logic       sck_fall;
  logic       single;

  assign sck_rise  = sck_rise_raw & ~cs_n_s;
  assign sck_fall  = sck_fall_raw & ~cs_n_s;
  assign rx_byte   = {rx_q, mosi_s};
  assign byte_done = sck_rise && (bit_cnt_q == 3'd7);
  assign single    = (mode_q == MODE_BYTE) || (mode_q == MODE_RSVD);

  assign mem_we    = byte_done && (state_q == ST_WDATA);
  assign mem_addr  = addr_q[AW-1:0];
  assign mem_wdata = rx_byte;

  function automatic logic [ADDR_W-1:0] next_addr(input logic [ADDR_W-1:0] a,
                                                  input acc_mode_e m);
    if (m == MODE_PAGE)
      return {a[ADDR_W-1:PAGE_BITS], a[PAGE_BITS-1:0] + 1'b1};
    else
      return a + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_CMD;
      bit_cnt_q <= '0;
      rx_q      <= '0;
      abyte_q   <= '0;
      is_read_q <= 1'b0;
      addr_q    <= '0;
      mode_q    <= MODE_SEQ;
      tx_q      <= '0;
      miso_q    <= 1'b0;
      miso_oe   <= 1'b0;
    end else if (cs_n_s) begin
      state_q   <= ST_CMD;
      bit_cnt_q <= '0;
      abyte_q   <= '0;
      tx_q      <= '0;
      miso_q    <= 1'b0;
      miso_oe   <= 1'b0;
    end else begin
      miso_oe <= 1'b1;
      if (sck_rise) begin
        bit_cnt_q <= bit_cnt_q + 3'd1;
        rx_q      <= {rx_q[5:0], mosi_s};
        if (bit_cnt_q == 3'd7) begin
          unique case (state_q)
            ST_CMD: begin
              abyte_q <= '0;
              if (rx_byte == OP_WRITE || rx_byte == OP_READ) begin
                state_q   <= ST_ADDR;
                is_read_q <= (rx_byte == OP_READ);
              end else if (rx_byte == OP_WRMODE) begin
                state_q <= ST_MODEW;
              end else if (rx_byte == OP_RDMODE) begin
                state_q <= ST_MODER;
              end else begin
                state_q <= ST_IGNORE;
              end
            end
            ST_ADDR: begin
              addr_q <= {addr_q[ADDR_W-9:0], rx_byte};
              if (abyte_q == 2'(ADDR_BYTES - 1))
                state_q <= is_read_q ? ST_RDATA : ST_WDATA;
              else
                abyte_q <= abyte_q + 2'd1;
            end
            ST_WDATA, ST_RDATA: begin
              if (single) state_q <= ST_IGNORE;
              else        addr_q  <= next_addr(addr_q, mode_q);
            end
            ST_MODEW: begin
              mode_q  <= acc_mode_e'(rx_byte[7:6]);
              state_q <= ST_IGNORE;
            end
            default: ;
          endcase
        end
      end
      if (sck_fall) begin
        if (bit_cnt_q == 3'd0 && state_q == ST_RDATA) begin
          miso_q <= rd_data[7];
          tx_q   <= {rd_data[6:0], 1'b0};
        end else if (bit_cnt_q == 3'd0 && state_q == ST_MODER) begin
          miso_q <= mode_q[1];
          tx_q   <= {mode_q[0], 7'b0};
        end else if (state_q == ST_RDATA || state_q == ST_MODER) begin
          miso_q <= tx_q[7];
          tx_q   <= {tx_q[6:0], 1'b0};
        end else begin
          miso_q <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/sram_spi_dev.sv
module sram_spi_dev
  import sram_spi_pkg::*;
#(
  parameter int   DEPTH        = 256,
  parameter int   SYNC_STAGES  = 2,
  parameter bit   USE_TRISTATE = 1'b0,
  localparam int  AW           = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          spi_sck,
  input  logic          spi_cs_n,
  input  logic          spi_mosi,
  output logic          spi_miso,
  output logic          spi_miso_oe,
  input  logic [AW-1:0] dbg_addr,
  output logic [7:0]    dbg_data
);

  logic              sck_rise;
  logic              sck_fall;
  logic              cs_n_s;
  logic              mosi_s;
  logic              mem_we;
  logic [AW-1:0]     mem_addr;
  logic [7:0]        mem_wdata;
  logic [7:0]        mem_rdata;
  logic              miso_q;
  logic              byte_done;
  ctl_state_e        state_q;
  acc_mode_e         mode_q;
  logic [ADDR_W-1:0] addr_q;

  sram_spi_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .sck      (spi_sck),
    .cs_n     (spi_cs_n),
    .mosi     (spi_mosi),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .cs_n_s   (cs_n_s),
    .mosi_s   (mosi_s)
  );

  sram_spi_ctrl #(.AW(AW)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .sck_rise_raw (sck_rise),
    .sck_fall_raw (sck_fall),
    .cs_n_s       (cs_n_s),
    .mosi_s       (mosi_s),
    .rd_data      (mem_rdata),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .miso_q       (miso_q),
    .miso_oe      (spi_miso_oe),
    .byte_done    (byte_done),
    .state_q      (state_q),
    .mode_q       (mode_q),
    .addr_q       (addr_q)
  );

  sram_spi_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk      (clk),
    .we       (mem_we),
    .waddr    (mem_addr),
    .wdata    (mem_wdata),
    .raddr    (mem_addr),
    .rdata    (mem_rdata),
    .dbg_addr (dbg_addr),
    .dbg_data (dbg_data)
  );

  generate
    if (USE_TRISTATE) begin : g_tri
      assign spi_miso = spi_miso_oe ? miso_q : 1'bz;
    end else begin : g_low
      assign spi_miso = spi_miso_oe & miso_q;
    end
  endgenerate

endmodule

// File: rtl/sram_spi_dev_chk.sv
module sram_spi_dev_chk
  import sram_spi_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              cs_n_s,
  input logic              sck_fall,
  input logic              byte_done,
  input logic              mem_we,
  input ctl_state_e        state_q,
  input acc_mode_e         mode_q,
  input logic [ADDR_W-1:0] addr_q,
  input logic              miso_q,
  input logic              spi_miso_oe
);

  // R9: deselect silences the output one clock later
  p_quiet_deselect_r9: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> (!spi_miso_oe && !miso_q));

  // R3: output bit only moves after a falling SCK edge (or deselect)
  p_miso_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
    (!sck_fall && !cs_n_s) |=> $stable(miso_q));

  // R4: sequential step
  p_seq_step_r4: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mode_q == MODE_SEQ) |=> (addr_q == $past(addr_q) + 24'd1));

  // R5: page wrap keeps upper bits
  p_page_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_we && mode_q == MODE_PAGE) |=>
      (addr_q[ADDR_W-1:PAGE_BITS] == $past(addr_q[ADDR_W-1:PAGE_BITS]) &&
       addr_q[PAGE_BITS-1:0] == $past(addr_q[PAGE_BITS-1:0]) + 5'd1));

  // R6: single access in byte mode
  p_byte_single_r6: assert property (@(posedge clk) disable iff (rst)
    (mem_we && (mode_q == MODE_BYTE || mode_q == MODE_RSVD)) |=> (state_q == ST_IGNORE));

  // R7: mode changes only at the end of a mode-write data byte
  p_mode_write_only_r7: assert property (@(posedge clk) disable iff (rst)
    !(byte_done && state_q == ST_MODEW) |=> $stable(mode_q));

  // R8: deselect returns the decoder to idle
  p_abort_idle_r8: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> (state_q == ST_CMD));

  // R10: nothing written while ignoring
  p_ignore_no_write_r10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IGNORE) |-> !mem_we);

endmodule

bind sram_spi_dev sram_spi_dev_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .cs_n_s      (cs_n_s),
  .sck_fall    (sck_fall),
  .byte_done   (byte_done),
  .mem_we      (mem_we),
  .state_q     (state_q),
  .mode_q      (mode_q),
  .addr_q      (addr_q),
  .miso_q      (miso_q),
  .spi_miso_oe (spi_miso_oe)
);

// File: tb/sram_spi_dev_bench.sv
module sram_spi_dev_bench;

  localparam int DEPTH = 256;
  localparam int AW    = $clog2(DEPTH);
  localparam int HALF  = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          spi_sck = 1'b0;
  logic          spi_cs_n = 1'b1;
  logic          spi_mosi = 1'b0;
  logic          spi_miso;
  logic          spi_miso_oe;
  logic [AW-1:0] dbg_addr = '0;
  logic [7:0]    dbg_data;

  always #2.5 clk = ~clk;

  sram_spi_dev #(.DEPTH(DEPTH)) u_sram_spi_dev (
    .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .dbg_addr(dbg_addr), .dbg_data(dbg_data)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [7:0] ref_mem [DEPTH];
  logic [1:0] mode_m = 2'b01;

  logic [7:0] exp_v[$];
  string      exp_r[$];
  logic [7:0] act_v[$];
  logic [7:0] wbuf[$];

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (act_v.size() > 0 && exp_v.size() > 0) begin
        logic [7:0] a, e;
        string r;
        a = act_v.pop_front();
        e = exp_v.pop_front();
        r = exp_r.pop_front();
        check(a, e, r);
      end
    end
  end

  function automatic logic [7:0] fill(input int a);
    return 8'((a * 3) + 1);
  endfunction

  function automatic logic [23:0] step_m(input logic [23:0] a);
    if (mode_m == 2'b10) return {a[23:5], a[4:0] + 5'd1};
    return a + 24'd1;
  endfunction

  function automatic bit single_m();
    return (mode_m == 2'b00) || (mode_m == 2'b11);
  endfunction

  task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < nbits; i++) begin
      spi_mosi = tx[7-i];
      repeat (HALF) @(negedge clk);
      rx = {rx[6:0], spi_miso};
      spi_sck = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b0;
    end
  endtask

  task automatic sel();
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic desel();
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic send_hdr(input logic [7:0] op, input logic [23:0] a);
    logic [7:0] rx;
    xfer(op, 8, rx);
    xfer(a[23:16], 8, rx);
    xfer(a[15:8], 8, rx);
    xfer(a[7:0], 8, rx);
  endtask

  task automatic do_write(input logic [23:0] a);
    logic [23:0] cur;
    logic [7:0]  rx;
    cur = a;
    sel();
    send_hdr(8'h02, a);
    for (int i = 0; i < wbuf.size(); i++) begin
      xfer(wbuf[i], 8, rx);
      if (!(single_m() && i > 0)) begin
        ref_mem[cur[AW-1:0]] = wbuf[i];
        cur = step_m(cur);
      end
    end
    desel();
    wbuf.delete();
  endtask

  task automatic do_read(input logic [23:0] a, input int n, input string req);
    logic [23:0] cur;
    logic [7:0]  rx;
    cur = a;
    sel();
    send_hdr(8'h03, a);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, 8, rx);
      if (single_m() && i > 0) exp_v.push_back(8'h00);
      else begin
        exp_v.push_back(ref_mem[cur[AW-1:0]]);
        cur = step_m(cur);
      end
      exp_r.push_back(req);
      act_v.push_back(rx);
    end
    desel();
  endtask

  task automatic set_mode(input logic [7:0] v);
    logic [7:0] rx;
    sel();
    xfer(8'h01, 8, rx);
    xfer(v, 8, rx);
    xfer(8'hFF, 8, rx);   // extra byte must be ignored (R7)
    desel();
    mode_m = v[7:6];
  endtask

  task automatic get_mode(input int n, input string req);
    logic [7:0] rx;
    sel();
    xfer(8'h05, 8, rx);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, 8, rx);
      exp_v.push_back({mode_m, 6'b0});
      exp_r.push_back(req);
      act_v.push_back(rx);
    end
    desel();
  endtask

  task automatic dbg_check(input int a, input logic [7:0] e, input string req);
    dbg_addr = AW'(a);
    @(negedge clk);
    @(negedge clk);
    check(dbg_data, e, req);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    logic [7:0] rx;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    // R1 / R9: reset state
    check({7'b0, spi_miso}, 8'h00, "R1 miso after reset");
    check({7'b0, spi_miso_oe}, 8'h00, "R9 oe after reset");
    // R1, R7: default sequential, repeated mode read
    get_mode(2, "R1 R7 default mode");

    // prefill region 0x20..0x5F in sequential mode (R4)
    for (int a = 32; a < 96; a++) wbuf.push_back(fill(a));
    do_write(24'h000020);
    dbg_check(8'h33, fill(8'h33), "R11 debug read prefill");

    // R2, R3, R4: sequential write/read with asymmetric bits
    wbuf.push_back(8'hA1); wbuf.push_back(8'hB2);
    wbuf.push_back(8'hC3); wbuf.push_back(8'hD4);
    do_write(24'h000010);
    dbg_check(8'h12, 8'hC3, "R11 debug read");
    do_read(24'h000010, 4, "R2 R3 R4 seq read");

    // R9: enable high while selected
    sel();
    check({7'b0, spi_miso_oe}, 8'h01, "R9 oe while selected");
    desel();

    // R2, R4: upper address bits ignored and wrap at top of array
    wbuf.push_back(8'h11); wbuf.push_back(8'h22); wbuf.push_back(8'h33);
    do_write(24'hABCDFE);
    dbg_check(8'h00, 8'h33, "R4 wrap to zero");
    do_read(24'h0000FF, 2, "R4 R2 wrap read");

    // R7, R5: page mode, low bits of mode byte ignored
    set_mode(8'hBF);
    get_mode(1, "R7 mode bits ignored page");
    wbuf.push_back(8'h5A); wbuf.push_back(8'h6B); wbuf.push_back(8'h7C);
    do_write(24'h00003E);
    dbg_check(8'h20, 8'h7C, "R5 page wrap write");
    dbg_check(8'h40, fill(8'h40), "R5 next page untouched");
    do_read(24'h00003F, 3, "R5 page read");

    // R6: byte mode (low bits set again)
    set_mode(8'h3F);
    get_mode(1, "R7 byte mode read back");
    wbuf.push_back(8'hE1); wbuf.push_back(8'hE2);
    do_write(24'h000050);
    dbg_check(8'h50, 8'hE1, "R6 first byte stored");
    dbg_check(8'h51, fill(8'h51), "R6 second byte ignored");
    do_read(24'h000050, 3, "R6 byte mode read zeros");

    // R6: reserved code behaves as byte mode
    set_mode(8'hC0);
    get_mode(1, "R7 reserved read back");
    do_read(24'h000022, 2, "R6 reserved single");

    // back to sequential
    set_mode(8'h7F);
    get_mode(1, "R7 seq read back");

    // R10: unknown command, then write-like bytes
    sel();
    xfer(8'h9A, 8, rx);
    xfer(8'h00, 8, rx); check(rx, 8'h00, "R10 miso zero");
    xfer(8'h00, 8, rx); check(rx, 8'h00, "R10 miso zero");
    xfer(8'h30, 8, rx); check(rx, 8'h00, "R10 miso zero");
    xfer(8'hEE, 8, rx); check(rx, 8'h00, "R10 miso zero");
    desel();
    dbg_check(8'h30, fill(8'h30), "R10 memory untouched");
    get_mode(1, "R10 mode untouched");

    // R8: abort in mid data byte
    sel();
    send_hdr(8'h02, 24'h000031);
    xfer(8'hFF, 4, rx);
    desel();
    dbg_check(8'h31, fill(8'h31), "R8 partial byte dropped");
    // R8: abort in mid command, then a clean read
    sel();
    xfer(8'hFF, 3, rx);
    desel();
    do_read(24'h000031, 2, "R8 decoder reset");

    // R9: quiet after deselect
    check({7'b0, spi_miso}, 8'h00, "R9 miso deselected");
    check({7'b0, spi_miso_oe}, 8'h00, "R9 oe deselected");

    repeat (10) @(negedge clk);
    if (exp_v.size() != 0) begin
      n_cmp++;
      n_bad++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_v.size());
    end
    finish_run();
  end

endmodule